// File: doc/BRIEF.md
# Serial Address and Mode Command Receiver

This block sits in front of a sequential-access video memory and turns two serial address streams into parallel memory commands. One line carries an 8-bit row address. The other carries an 8-bit word that holds a 6-bit column and two mode bits. Both arrive least significant bit first, and one bit enters on each qualified rising edge of the address clock. The memory-enable strobe is idle high. When it falls, the block captures both words, and that edge marks the boundary of a memory cycle.

A command captured in one memory cycle only takes effect at the next falling edge of the strobe. At that edge the block emits a one-cycle command carrying an operation, a row and a column. There are four operations: read into output port A, read into output port B, write from the input port, and refresh. A refresh ignores the external row and column. It uses an internal row counter instead, which steps through the valid rows and wraps around.

After reset, the block waits through a fixed number of memory-enable cycles before it treats anything as a command. Rows above the valid range are rejected with an error pulse instead of a command.

Top module: `addr_cmd_rx`

## Requirements
- R1: While `shift_en` is high on a rising clock edge, each 8-bit serial word shifts one bit. Row bits come from `row_bit` and column/mode bits come from `cm_bit`. After eight shifts, the first bit sent is bit 0 of the word.
- R2: A falling edge of `men` is seen as `men` low at a clock edge where it was high at the previous edge. It captures both words. The command from a capture is issued at the next such falling edge. `cmd_valid` is high for exactly the one clock after that edge.
- R3: In the column/mode word, bits 0 to 5 are the column, bit 6 is M0 and bit 7 is M1. `cmd_op` = {M1,M0}: 00 reads to port A, 01 reads to port B, 10 writes from the input port, 11 refreshes. For a non-refresh command, `cmd_row` and `cmd_col` are the captured row and column.
- R4: A refresh command ignores the external row and column. `cmd_row` is the internal refresh row, `cmd_col` is 0, and an external row of any value, including 212 to 255, raises no error.
- R5: The refresh row is 0 after reset. It advances by one after each issued refresh command and wraps from ROWS-1 (211) to 0.
- R6: `ready` is low after reset. It goes high after the WARMUP-th (8th) falling edge of `men` and stays high. Captures made at edges while `ready` is low are discarded, so they never produce a command or an error.
- R7: A non-refresh capture whose row is ROWS (212) or above issues no command. Instead, `range_err` is high for one clock at the edge where the command would have been issued.
- R8: During and right after reset, `cmd_valid`, `range_err` and `ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Address clock rising-edge qualifier; shifts both serial lines |
| row_bit | input | 1 | Serial row address bit, LSB first |
| cm_bit | input | 1 | Serial column-plus-mode bit, LSB first |
| men | input | 1 | Memory-enable strobe, idle high, captures on falling edge |
| ready | output | 1 | Warm-up complete |
| cmd_valid | output | 1 | One-clock command pulse |
| cmd_op | output | 2 | Operation {M1,M0} |
| cmd_row | output | ROW_W | Row for the command (internal row on refresh) |
| cmd_col | output | COL_W | Column for the command (0 on refresh) |
| range_err | output | 1 | One-clock pulse for a rejected out-of-range row |

## Verification
The bench builds the block with its defaults: an 8-bit row, a 6-bit column, 212 valid rows and an 8-cycle warm-up. Because the row word is only 8 bits wide, the bench can sweep every row value from 0 to 255 under every mode. The sweep puts every out-of-range row, as well as refreshes carrying out-of-range external rows, on the ports. The 256 refreshes in that sweep also carry the internal row counter past its wrap at 211.

// File: rtl/acr_pkg.sv
package acr_pkg;
  typedef enum logic [1:0] {
    OP_RD_A    = 2'b00,
    OP_RD_B    = 2'b01,
    OP_WR_IN   = 2'b10,
    OP_REFRESH = 2'b11
  } acr_op_e;
endpackage

// File: rtl/acr_shift.sv
module acr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  // LSB-first: newest bit enters at the top and moves down
  always_comb begin
    q_nxt = q;
    if (shift_en) q_nxt = {din, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/acr_warmup.sv
module acr_warmup #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic ready
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] DONE = CW'(CYCLES);

  logic [CW-1:0] cnt, cnt_nxt;

  assign ready = (cnt == DONE);

  always_comb begin
    cnt_nxt = cnt;
    if (tick && !ready) cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/acr_refresh_ctr.sv
module acr_refresh_ctr #(
  parameter int ROW_W = 8,
  parameter int ROWS  = 212
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

  logic [ROW_W-1:0] row_nxt;

  always_comb begin
    row_nxt = row;
    if (step) row_nxt = (row == LAST) ? '0 : row + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row <= '0;
    else        row <= row_nxt;
  end
endmodule

// File: rtl/addr_cmd_rx.sv
module addr_cmd_rx #(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int ROWS   = 212,
  parameter int WARMUP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             row_bit,
  input  logic             cm_bit,
  input  logic             men,
  output logic             ready,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             range_err
);
  import acr_pkg::*;

  localparam int CM_W = COL_W + 2;
  localparam logic [ROW_W:0] ROW_LIMIT = (ROW_W + 1)'(ROWS);

  logic [ROW_W-1:0] row_q;
  logic [CM_W-1:0]  cm_q;
  logic [ROW_W-1:0] rfr_row;
  logic             men_q;
  logic             fall, accept, issue, rfr_step;
  acr_op_e          cap_op;
  logic             cap_bad;

  // pending command (captured in cycle N, issued in cycle N+1)
  logic             pend_valid, pend_valid_nxt;
  logic             pend_bad,   pend_bad_nxt;
  acr_op_e          pend_op,    pend_op_nxt;
  logic [ROW_W-1:0] pend_row,   pend_row_nxt;
  logic [COL_W-1:0] pend_col,   pend_col_nxt;

  // output registers
  logic             cmd_valid_nxt, range_err_nxt;
  logic [1:0]       cmd_op_nxt;
  logic [ROW_W-1:0] cmd_row_nxt;
  logic [COL_W-1:0] cmd_col_nxt;

  acr_shift #(.W(ROW_W)) u_row_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(row_bit), .q(row_q)
  );

  acr_shift #(.W(CM_W)) u_cm_sr (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(cm_bit), .q(cm_q)
  );

  acr_warmup #(.CYCLES(WARMUP)) u_warm (
    .clk(clk), .rst_n(rst_n), .tick(fall), .ready(ready)
  );

  acr_refresh_ctr #(.ROW_W(ROW_W), .ROWS(ROWS)) u_rfr (
    .clk(clk), .rst_n(rst_n), .step(rfr_step), .row(rfr_row)
  );

  assign fall     = men_q & ~men;
  assign accept   = fall & ready;
  assign issue    = fall & pend_valid;
  assign rfr_step = issue & ~pend_bad & (pend_op == OP_REFRESH);
  assign cap_op   = acr_op_e'(cm_q[CM_W-1:COL_W]);
  assign cap_bad  = (cap_op != OP_REFRESH) && ({1'b0, row_q} >= ROW_LIMIT);

  always_comb begin
    pend_valid_nxt = pend_valid;
    pend_bad_nxt   = pend_bad;
    pend_op_nxt    = pend_op;
    pend_row_nxt   = pend_row;
    pend_col_nxt   = pend_col;
    if (fall) begin
      pend_valid_nxt = accept;
      pend_bad_nxt   = cap_bad;
      pend_op_nxt    = cap_op;
      pend_row_nxt   = row_q;
      pend_col_nxt   = cm_q[COL_W-1:0];
    end
  end

  always_comb begin
    cmd_valid_nxt = issue & ~pend_bad;
    range_err_nxt = issue & pend_bad;
    cmd_op_nxt    = cmd_op;
    cmd_row_nxt   = cmd_row;
    cmd_col_nxt   = cmd_col;
    if (issue && !pend_bad) begin
      cmd_op_nxt = pend_op;
      if (pend_op == OP_REFRESH) begin
        cmd_row_nxt = rfr_row;
        cmd_col_nxt = '0;
      end else begin
        cmd_row_nxt = pend_row;
        cmd_col_nxt = pend_col;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q      <= 1'b1;
      pend_valid <= 1'b0;
      pend_bad   <= 1'b0;
      pend_op    <= OP_RD_A;
      pend_row   <= '0;
      pend_col   <= '0;
      cmd_valid  <= 1'b0;
      range_err  <= 1'b0;
      cmd_op     <= '0;
      cmd_row    <= '0;
      cmd_col    <= '0;
    end else begin
      men_q      <= men;
      pend_valid <= pend_valid_nxt;
      pend_bad   <= pend_bad_nxt;
      pend_op    <= pend_op_nxt;
      pend_row   <= pend_row_nxt;
      pend_col   <= pend_col_nxt;
      cmd_valid  <= cmd_valid_nxt;
      range_err  <= range_err_nxt;
      cmd_op     <= cmd_op_nxt;
      cmd_row    <= cmd_row_nxt;
      cmd_col    <= cmd_col_nxt;
    end
  end
endmodule

// File: rtl/addr_cmd_rx_chk.sv
module addr_cmd_rx_chk #(
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int ROWS  = 212
) (
  input logic             clk,
  input logic             rst_n,
  input logic             men,
  input logic             ready,
  input logic             cmd_valid,
  input logic [1:0]       cmd_op,
  input logic [ROW_W-1:0] cmd_row,
  input logic [COL_W-1:0] cmd_col,
  input logic             range_err
);
  p_cmd_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (!$past(men) && $past(men, 2)));

  p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_refresh_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11) |-> (cmd_col == '0));

  p_row_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ({1'b0, cmd_row} < (ROW_W + 1)'(ROWS)));

  p_err_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && range_err));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || range_err) |-> ready);

  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  always @(posedge clk)
    if (!rst_n) p_reset_quiet_r8: assert (!cmd_valid && !range_err);
endmodule

bind addr_cmd_rx addr_cmd_rx_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .ROWS(ROWS)) u_chk (
  .clk(clk), .rst_n(rst_n), .men(men), .ready(ready), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col), .range_err(range_err)
);

// File: tb/addr_cmd_rx_bench.sv
module addr_cmd_rx_bench;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 6;
  localparam int ROWS   = 212;
  localparam int WARMUP = 8;

  logic clk = 1'b0;
  logic rst_n, shift_en, row_bit, cm_bit, men;
  logic ready, cmd_valid, range_err;
  logic [1:0] cmd_op;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic o_valid, o_err, o_ready;
  logic [1:0] o_op;
  logic [ROW_W-1:0] o_row;
  logic [COL_W-1:0] o_col;

  always #2 clk = ~clk;

  addr_cmd_rx #(.ROW_W(ROW_W), .COL_W(COL_W), .ROWS(ROWS), .WARMUP(WARMUP)) u_addr_cmd_rx (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .row_bit(row_bit), .cm_bit(cm_bit),
    .men(men), .ready(ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .range_err(range_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // shift both words LSB first, then one memory-enable cycle; observe after the fall
  task automatic mem_cycle(input logic [7:0] r, input logic [7:0] cm);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      row_bit  = r[i];
      cm_bit   = cm[i];
      shift_en = 1'b1;
      @(negedge clk);
      shift_en = 1'b0;
    end
    men = 1'b0;
    @(negedge clk);
    o_valid = cmd_valid; o_err = range_err; o_ready = ready;
    o_op = cmd_op; o_row = cmd_row; o_col = cmd_col;
    men = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit       p_valid;
    bit [7:0] p_row, p_cm;
    int       rfr;
    rst_n = 1'b0; shift_en = 1'b0; row_bit = 1'b0; cm_bit = 1'b0; men = 1'b1;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!cmd_valid, "R8 cmd_valid in reset", cmd_valid, 0);
    chk(!range_err, "R8 range_err in reset", range_err, 0);
    chk(!ready, "R8 ready in reset", ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ready && !cmd_valid, "R8 state after reset", ready, 0);

    // R6 warm-up: captures discarded, ready after WARMUP edges
    for (int k = 1; k <= WARMUP; k++) begin
      mem_cycle(8'(k * 3), 8'(k * 17));
      chk(!o_valid && !o_err, "R6 no command during warm-up", o_valid, 0);
      chk(o_ready == (k >= WARMUP), "R6 ready timing", o_ready, int'(k >= WARMUP));
    end
    // first accepted capture; the edge issuing it must not carry a warm-up command
    mem_cycle(8'd5, 8'd0);
    chk(!o_valid && !o_err, "R6 discarded warm-up capture stays silent", o_valid, 0);
    p_valid = 1'b1; p_row = 8'd5; p_cm = 8'd0;
    rfr = 0;

    // R1 R2 R3 R4 R5 R7 sweep of every row under every mode
    for (int r = 0; r < 256; r++) begin
      for (int m = 0; m < 4; m++) begin
        logic [7:0] ncm;
        ncm = {2'(m), 6'((r * 7 + m) % 64)};
        mem_cycle(8'(r), ncm);
        if (p_cm[7:6] == 2'b11) begin
          chk(o_valid && !o_err, "R4 refresh issued", o_valid, 1);
          chk(o_op == 2'b11, "R3 refresh op", o_op, 3);
          chk(o_row == 8'(rfr), "R5 refresh row", o_row, rfr);
          chk(o_col == 0, "R4 refresh col zero", o_col, 0);
          rfr = (rfr == ROWS - 1) ? 0 : rfr + 1;
        end else if (p_row >= ROWS) begin
          chk(!o_valid && o_err, "R7 out-of-range rejected", o_err, 1);
        end else begin
          chk(o_valid && !o_err, "R2 command issued next cycle", o_valid, 1);
          chk(o_op == p_cm[7:6], "R3 op decode", o_op, p_cm[7:6]);
          chk(o_row == p_row, "R1 row deserialized", o_row, p_row);
          chk(o_col == p_cm[5:0], "R1 col deserialized", o_col, p_cm[5:0]);
        end
        p_row = 8'(r); p_cm = ncm;
      end
    end
    chk(p_valid, "R5 sweep completed", 1, 1);

    // R2 no command without a new falling edge
    repeat (10) @(negedge clk);
    chk(!cmd_valid && !range_err, "R2 quiet without strobe edge", cmd_valid, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule